// File: doc/BRIEF.md
# Per-Vector Message Interrupt Table Engine

The engine keeps a table of interrupt vectors. Each vector has its own 64-bit message target address, its own 32-bit message data word and its own mask bit. Because every vector has its own target, different vectors can be steered to different processors. Software reads and writes the table through a word-wide register port. Interrupt sources raise one-cycle pulses on `src_fire`. Each pulse becomes a pending request for that source's vector.

A pending vector is eligible when all three hold: its own mask is clear, the function-wide mask is clear and the function-wide enable is set. A round-robin arbiter picks one eligible vector. The sequencer then latches that vector's address and data and clears its pending bit. It presents the latched values as a memory-write request on a valid/ready pair. A masked vector keeps its pending bit, which software can see on `pending_o`. When the vector later becomes eligible, exactly one write is issued.

While the device still has posted data writes outstanding (`post_busy` high), the request waits. An interrupt message therefore never overtakes earlier data.

The sequencer has three states. S_IDLE moves to S_SEND on a grant while `post_busy` is low, and to S_DRAIN on a grant while `post_busy` is high. S_DRAIN moves to S_SEND once `post_busy` is low. S_SEND holds the request and returns to S_IDLE when `msg_ready` is high.

Top module: `xvec_engine`

## Requirements
- R1: After reset every vector's mask reads 1, its address and data words read 0, `pending_o` is all zero and `msg_valid` is 0.
- R2: Vector v occupies byte offsets 16*v to 16*v+15 of the register port. Word offset 0 holds address bits 31:0, offset 4 holds address bits 63:32, offset 8 holds the data word and offset 12 is control, with the mask in bit 0 and the other bits reading 0. A write takes effect at the next clock edge, and `reg_rdata` returns the addressed word without delay.
- R3: A pulse on an unmasked, eligible vector produces exactly one write whose `msg_addr` and `msg_data` equal that vector's table entry.
- R4: A pulse on a masked vector sets its `pending_o` bit and emits no write. Clearing the mask then emits exactly one write for it and clears the pending bit.
- R5: While `func_mask` is 1, every vector behaves as masked and pending bits still set. Clearing `func_mask` releases the pending writes.
- R6: While `func_en` is 0, no write is emitted and pending bits accumulate. Setting `func_en` releases them.
- R7: `msg_valid` never rises in a cycle that follows a cycle with `post_busy` high. A request accepted while `post_busy` is high is emitted after `post_busy` falls.
- R8: A request carries the table values latched at acceptance. Writing that vector's table entry while the request waits does not change `msg_addr` or `msg_data`.
- R9: Eligible pending vectors are granted in round-robin order. The search starts at the vector after the last one granted and wraps from NUM_VEC-1 to 0.
- R10: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_addr` and `msg_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| func_en | input | 1 | Function-wide enable |
| func_mask | input | 1 | Function-wide mask |
| src_fire | input | NUM_VEC | One-cycle interrupt pulses, one bit per vector |
| post_busy | input | 1 | Earlier posted data writes still outstanding |
| msg_valid | output | 1 | Memory-write request valid |
| msg_ready | input | 1 | Memory-write request accepted downstream |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message data word |
| pending_o | output | NUM_VEC | Pending bit for each vector |

## Verification
A corrupted pending bit shows on `pending_o` one clock after the pulse. It shows up as a write that never appears or as a duplicate write within a few cycles of eligibility. A wrong arbiter pointer shows as the wrong order of `msg_data` values when several vectors are released together. A latch or sequencer fault shows directly on `msg_addr` and `msg_data`, either while the request stalls or once `post_busy` is removed.

// File: rtl/xvec_pkg.sv
package xvec_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_DRAIN = 2'd1,
        S_SEND  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
    } vec_entry_t;

    localparam int WORD_ADDR_LO = 0;
    localparam int WORD_ADDR_HI = 1;
    localparam int WORD_DATA    = 2;
    localparam int WORD_CTRL    = 3;
endpackage

// File: rtl/xvec_table.sv
module xvec_table
    import xvec_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int IDX_W   = 3,
    parameter int REG_AW  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [IDX_W-1:0]   rd_idx,
    output vec_entry_t         rd_entry,
    output logic [NUM_VEC-1:0] mask_vec
);
    logic [31:0] addr_lo [NUM_VEC];
    logic [31:0] addr_hi [NUM_VEC];
    logic [31:0] data_w  [NUM_VEC];

    logic [IDX_W-1:0] reg_idx;
    logic [IDX_W:0]   reg_idx_ext;
    logic             idx_ok;
    logic [1:0]       word_sel;

    assign reg_idx     = reg_addr[REG_AW-1:4];
    assign reg_idx_ext = {1'b0, reg_idx};
    assign idx_ok      = reg_idx_ext < (IDX_W+1)'(NUM_VEC);
    assign word_sel    = reg_addr[3:2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VEC; v++) begin
                addr_lo[v]  <= '0;
                addr_hi[v]  <= '0;
                data_w[v]   <= '0;
                mask_vec[v] <= 1'b1;
            end
        end else if (reg_wr && idx_ok) begin
            unique case (word_sel)
                2'(WORD_ADDR_LO): addr_lo[reg_idx]  <= reg_wdata;
                2'(WORD_ADDR_HI): addr_hi[reg_idx]  <= reg_wdata;
                2'(WORD_DATA):    data_w[reg_idx]   <= reg_wdata;
                2'(WORD_CTRL):    mask_vec[reg_idx] <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (idx_ok) begin
            unique case (word_sel)
                2'(WORD_ADDR_LO): reg_rdata = addr_lo[reg_idx];
                2'(WORD_ADDR_HI): reg_rdata = addr_hi[reg_idx];
                2'(WORD_DATA):    reg_rdata = data_w[reg_idx];
                2'(WORD_CTRL):    reg_rdata = {31'b0, mask_vec[reg_idx]};
                default:          reg_rdata = '0;
            endcase
        end
    end

    assign rd_entry.addr = {addr_hi[rd_idx], addr_lo[rd_idx]};
    assign rd_entry.data = data_w[rd_idx];
endmodule

// File: rtl/xvec_rr_arb.sv
module xvec_rr_arb #(
    parameter int NUM_VEC = 8,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] req,
    input  logic               adv,
    output logic               gnt_any,
    output logic [IDX_W-1:0]   gnt_idx
);
    logic [IDX_W-1:0] ptr;

    always_comb begin
        int c;
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            c = int'(ptr) + i;
            if (c >= NUM_VEC) c = c - NUM_VEC;
            if (!gnt_any && req[c]) begin
                gnt_any = 1'b1;
                gnt_idx = IDX_W'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            if (int'(gnt_idx) == NUM_VEC - 1) ptr <= '0;
            else                              ptr <= gnt_idx + 1'b1;
        end
    end
endmodule

// File: rtl/xvec_seq.sv
module xvec_seq
    import xvec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        gnt_any,
    input  vec_entry_t  entry,
    input  logic        post_busy,
    input  logic        msg_ready,
    output logic        accept,
    output logic        msg_valid,
    output logic [63:0] msg_addr,
    output logic [31:0] msg_data
);
    seq_state_t state, state_nx;
    vec_entry_t held;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (gnt_any) state_nx = post_busy ? S_DRAIN : S_SEND;
            S_DRAIN: if (!post_busy) state_nx = S_SEND;
            S_SEND:  if (msg_ready) state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      held <= '0;
        else if (accept) held <= entry;
    end

    always_comb begin
        accept    = (state == S_IDLE) && gnt_any;
        msg_valid = (state == S_SEND);
        msg_addr  = held.addr;
        msg_data  = held.data;
    end
endmodule

// File: rtl/xvec_engine.sv
module xvec_engine
    import xvec_pkg::*;
#(
    parameter  int NUM_VEC = 8,
    localparam int IDX_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
    localparam int REG_AW  = IDX_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               func_en,
    input  logic               func_mask,
    input  logic [NUM_VEC-1:0] src_fire,
    input  logic               post_busy,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data,
    output logic [NUM_VEC-1:0] pending_o
);
    logic [NUM_VEC-1:0] pend;
    logic [NUM_VEC-1:0] mask_vec;
    logic [NUM_VEC-1:0] elig;
    logic [NUM_VEC-1:0] clr;
    logic               gnt_any;
    logic [IDX_W-1:0]   gnt_idx;
    logic               accept;
    vec_entry_t         entry;

    xvec_table #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W), .REG_AW(REG_AW)) i_table (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_idx(gnt_idx),
        .rd_entry(entry), .mask_vec(mask_vec)
    );

    assign elig = pend & ~mask_vec & {NUM_VEC{func_en & ~func_mask}};

    xvec_rr_arb #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) i_arb (
        .clk(clk), .rst_n(rst_n), .req(elig), .adv(accept),
        .gnt_any(gnt_any), .gnt_idx(gnt_idx)
    );

    xvec_seq i_seq (
        .clk(clk), .rst_n(rst_n), .gnt_any(gnt_any), .entry(entry),
        .post_busy(post_busy), .msg_ready(msg_ready), .accept(accept),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    always_comb begin
        clr = '0;
        if (accept) clr[gnt_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | src_fire;
    end

    assign pending_o = pend;
endmodule

// File: rtl/xvec_checker.sv
module xvec_checker #(
    parameter int NUM_VEC = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               func_en,
    input logic               func_mask,
    input logic               post_busy,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [63:0]        msg_addr,
    input logic [31:0]        msg_data,
    input logic               accept,
    input logic [IDX_W-1:0]   gnt_idx,
    input logic [NUM_VEC-1:0] mask_vec,
    input logic [NUM_VEC-1:0] pend,
    input logic [NUM_VEC-1:0] src_fire
);
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    a_r7_no_overtake: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> !$past(post_busy));

    a_r4_masked_not_granted: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !mask_vec[gnt_idx]);

    a_r5_func_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        func_mask |-> !accept);

    a_r6_disable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !func_en |-> !accept);

    a_r3_pending_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !src_fire[gnt_idx]) |=> !pend[$past(gnt_idx)]);
endmodule

bind xvec_engine xvec_checker #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .func_en(func_en), .func_mask(func_mask),
    .post_busy(post_busy), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data), .accept(accept),
    .gnt_idx(gnt_idx), .mask_vec(mask_vec), .pend(pend), .src_fire(src_fire)
);

// File: tb/test_xvec_engine.sv
module test_xvec_engine;
    localparam int NV = 8;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          func_en = 1'b0;
    logic          func_mask = 1'b0;
    logic [NV-1:0] src_fire = '0;
    logic          post_busy = 1'b0;
    logic          msg_valid;
    logic          msg_ready = 1'b1;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;
    logic [NV-1:0] pending_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [63:0] log_addr [64];
    logic [31:0] log_data [64];
    int          log_cnt = 0;

    always #2 clk = ~clk;

    xvec_engine #(.NUM_VEC(NV)) i_xvec_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .func_en(func_en),
        .func_mask(func_mask), .src_fire(src_fire), .post_busy(post_busy),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
        .msg_data(msg_data), .pending_o(pending_o)
    );

    always @(posedge clk) begin
        if (rst_n && msg_valid && msg_ready && log_cnt < 64) begin
            log_addr[log_cnt] = msg_addr;
            log_data[log_cnt] = msg_data;
            log_cnt = log_cnt + 1;
        end
    end

    function automatic logic [63:0] vaddr(int v);
        return {32'hA500_0000 | 32'(v), 32'h0000_1000 * 32'(v + 1)};
    endfunction

    function automatic logic [31:0] vdata(int v);
        return 32'hD000_0000 + 32'(v);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = AW'(a);
        #1 d = reg_rdata;
    endtask

    task automatic fire(input logic [NV-1:0] m);
        @(negedge clk);
        src_fire = m;
        @(negedge clk);
        src_fire = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk(msg_valid == 1'b0, "R1 valid", 64'(msg_valid), 0);
        chk(pending_o == '0, "R1 pending", 64'(pending_o), 0);
        for (int v = 0; v < NV; v++) begin
            reg_read(16*v + 12, d);
            chk(d == 32'h1, "R1 mask", 64'(d), 1);
            reg_read(16*v + 8, d);
            chk(d == 32'h0, "R1 data", 64'(d), 0);
        end
        reg_read(16*3 + 4, d);
        chk(d == 32'h0, "R1 addr hi", 64'(d), 0);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        for (int v = 0; v < NV; v++) begin
            reg_write(16*v + 0, vaddr(v)[31:0]);
            reg_write(16*v + 4, vaddr(v)[63:32]);
            reg_write(16*v + 8, vdata(v));
        end
        reg_write(16*2 + 12, 32'hFFFF_FFFF);
        reg_read(16*2 + 0, d);
        chk(d == vaddr(2)[31:0], "R2 addr lo", 64'(d), 64'(vaddr(2)[31:0]));
        reg_read(16*2 + 4, d);
        chk(d == vaddr(2)[63:32], "R2 addr hi", 64'(d), 64'(vaddr(2)[63:32]));
        reg_read(16*2 + 8, d);
        chk(d == vdata(2), "R2 data", 64'(d), 64'(vdata(2)));
        reg_read(16*2 + 12, d);
        chk(d == 32'h1, "R2 ctrl", 64'(d), 1);
    endtask

    task automatic t_unmasked;
        int base;
        reg_write(16*6 + 12, 32'h0);
        base = log_cnt;
        fire(8'h40);
        cyc(10);
        chk(log_cnt == base + 1, "R3 count", 64'(log_cnt - base), 1);
        chk(log_addr[base] == vaddr(6), "R3 addr", log_addr[base], vaddr(6));
        chk(log_data[base] == vdata(6), "R3 data", 64'(log_data[base]), 64'(vdata(6)));
    endtask

    task automatic t_masked;
        int base;
        base = log_cnt;
        fire(8'h04);
        cyc(10);
        chk(pending_o[2] == 1'b1, "R4 pending set", 64'(pending_o), 64'h04);
        chk(log_cnt == base, "R4 no write while masked", 64'(log_cnt - base), 0);
        reg_write(16*2 + 12, 32'h0);
        cyc(10);
        chk(log_cnt == base + 1, "R4 one write on unmask", 64'(log_cnt - base), 1);
        chk(log_data[base] == vdata(2), "R4 data", 64'(log_data[base]), 64'(vdata(2)));
        chk(pending_o[2] == 1'b0, "R4 pending cleared", 64'(pending_o), 0);
    endtask

    task automatic t_fmask;
        int base;
        base = log_cnt;
        func_mask = 1'b1;
        fire(8'h40);
        cyc(10);
        chk(pending_o[6] == 1'b1, "R5 pending under func mask", 64'(pending_o), 64'h40);
        chk(log_cnt == base, "R5 no write", 64'(log_cnt - base), 0);
        @(negedge clk) func_mask = 1'b0;
        cyc(10);
        chk(log_cnt == base + 1, "R5 released", 64'(log_cnt - base), 1);
        chk(log_data[base] == vdata(6), "R5 data", 64'(log_data[base]), 64'(vdata(6)));
    endtask

    task automatic t_fen;
        int base;
        base = log_cnt;
        func_en = 1'b0;
        fire(8'h44);
        cyc(10);
        chk(pending_o == 8'h44, "R6 accumulate", 64'(pending_o), 64'h44);
        chk(log_cnt == base, "R6 no write", 64'(log_cnt - base), 0);
        @(negedge clk) func_en = 1'b1;
        cyc(12);
        chk(log_cnt == base + 2, "R6 released", 64'(log_cnt - base), 2);
        chk(log_data[base] == vdata(2), "R6 first (R9 order)", 64'(log_data[base]), 64'(vdata(2)));
        chk(log_data[base+1] == vdata(6), "R6 second (R9 order)", 64'(log_data[base+1]), 64'(vdata(6)));
    endtask

    task automatic t_order;
        int base;
        base = log_cnt;
        post_busy = 1'b1;
        fire(8'h40);
        cyc(10);
        chk(msg_valid == 1'b0, "R7 held while busy", 64'(msg_valid), 0);
        chk(log_cnt == base, "R7 no write while busy", 64'(log_cnt - base), 0);
        @(negedge clk) post_busy = 1'b0;
        cyc(6);
        chk(log_cnt == base + 1, "R7 emitted after busy", 64'(log_cnt - base), 1);
    endtask

    task automatic t_hold;
        int base;
        logic [63:0] a0;
        base = log_cnt;
        msg_ready = 1'b0;
        fire(8'h40);
        cyc(5);
        chk(msg_valid == 1'b1, "R10 valid", 64'(msg_valid), 1);
        chk(msg_addr == vaddr(6), "R10 addr", msg_addr, vaddr(6));
        a0 = msg_addr;
        cyc(4);
        chk(msg_valid == 1'b1 && msg_addr == a0 && msg_data == vdata(6), "R10 stable", msg_addr, a0);
        @(negedge clk) msg_ready = 1'b1;
        cyc(4);
        chk(log_cnt == base + 1, "R10 single transfer", 64'(log_cnt - base), 1);
    endtask

    task automatic t_latch;
        int base;
        logic [31:0] d;
        base = log_cnt;
        msg_ready = 1'b0;
        fire(8'h40);
        cyc(5);
        reg_write(16*6 + 8, 32'h1234_5678);
        reg_write(16*6 + 0, 32'h0BAD_0000);
        cyc(1);
        chk(msg_data == vdata(6), "R8 data latched", 64'(msg_data), 64'(vdata(6)));
        chk(msg_addr == vaddr(6), "R8 addr latched", msg_addr, vaddr(6));
        @(negedge clk) msg_ready = 1'b1;
        cyc(4);
        chk(log_cnt == base + 1 && log_data[base] == vdata(6), "R8 sent old", 64'(log_data[base]), 64'(vdata(6)));
        reg_read(16*6 + 8, d);
        chk(d == 32'h1234_5678, "R8 table updated", 64'(d), 64'h1234_5678);
        reg_write(16*6 + 8, vdata(6));
        reg_write(16*6 + 0, vaddr(6)[31:0]);
    endtask

    task automatic t_rr;
        int base;
        base = log_cnt;
        reg_write(16*1 + 12, 32'h0);
        reg_write(16*5 + 12, 32'h0);
        reg_write(16*7 + 12, 32'h0);
        func_mask = 1'b1;
        fire(8'hA2);
        @(negedge clk) func_mask = 1'b0;
        cyc(20);
        chk(log_cnt == base + 3, "R9 count", 64'(log_cnt - base), 3);
        chk(log_data[base]   == vdata(7), "R9 first", 64'(log_data[base]),   64'(vdata(7)));
        chk(log_data[base+1] == vdata(1), "R9 second", 64'(log_data[base+1]), 64'(vdata(1)));
        chk(log_data[base+2] == vdata(5), "R9 third", 64'(log_data[base+2]), 64'(vdata(5)));
    endtask

    initial begin
        cyc(4);
        @(negedge clk) rst_n = 1'b1;
        cyc(1);
        t_reset();
        func_en = 1'b1;
        t_regmap();
        t_unmasked();
        t_masked();
        t_fmask();
        t_fen();
        t_order();
        t_hold();
        t_latch();
        t_rr();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule